// File: doc/BRIEF.md
# Multi-Waveform Direct Digital Synthesis Generator

This block produces a stream of 8-bit unsigned samples for one of four periodic waveforms: sine, sawtooth, square or triangle. A 32-bit tuning word is captured on a load strobe. A 32-bit phase accumulator adds the captured word on every clock. With a 50 MHz clock, the output frequency is the tuning word times 50 MHz divided by 2^32.

The upper phase bits address an internally computed 512-entry sine table. The top eight phase bits also feed three arithmetic waveform generators. A 2-bit selector picks one waveform, and the chosen sample is registered. An amplitude stage then multiplies the sample by a 3-bit factor, or divides it by that factor, and registers the result on the output.

Top module: `dds_siggen`

## Requirements
- R1: The tuning-word register resets to 0 asynchronously when `rst_n` is low. It takes `tune_word` on a rising edge where `load` is high, and it keeps its value on every other edge.
- R2: On every rising edge out of reset, the phase accumulator becomes its previous value plus the previously held tuning word, modulo 2^32. It resets to 0.
- R3: Select code 00 gives the sine waveform. The table index is phase bits [31:23]. Entry k is round(128 + 128·sin(2πk/512)), and a value of 256 is stored as 255.
- R4: Select code 01 gives the sawtooth, which equals phase bits [31:24].
- R5: Select code 10 gives the square wave. It is 255 when phase bit 31 is 1 and 0 otherwise.
- R6: Select code 11 gives the triangle wave. It is {phase[30:24], 0} when phase bit 31 is 0. It is {~phase[30:24], 0} when phase bit 31 is 1.
- R7: The selector is applied per sample, so changing `wave_sel` on any cycle changes the waveform of the sample taken on that cycle.
- R8: The phase and `wave_sel` seen at one rising edge reach `sample_out` two edges later. `amp_up` and `amp_factor` act one edge before the output updates.
- R9: When `amp_up` is 1, the output is the sample times `amp_factor`, saturating at 255. A factor of 0 gives 0.
- R10: When `amp_up` is 0, the output is the sample divided by `amp_factor` using integer division. A factor of 0 is treated as 1.
- R11: While reset is asserted, `sample_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture strobe for the tuning word |
| tune_word | input | 32 | New tuning word |
| wave_sel | input | 2 | Waveform: 00 sine, 01 sawtooth, 10 square, 11 triangle |
| amp_up | input | 1 | 1 multiplies the sample, 0 divides it |
| amp_factor | input | 3 | Amplitude factor |
| sample_out | output | 8 | Scaled unsigned sample |

## Verification
The bench sweeps the whole sine table one entry per clock. A table with a wrong rounding or with no clamp at the crest would show up as an off-by-one sample, or as a wrapped 0 where 255 belongs. It drives a changed word on the bus while the strobe is low; a register that loads without the strobe would change the sawtooth slope. It switches the selector and the factor on every cycle, so a latency slip of one stage mismatches at once. It also runs multiply with factors 7 and 0, divide with factors 5 and 0, and a tuning word that wraps the accumulator. These catch a missing saturation, a divide by zero and a carry handled wrongly.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [1:0] {
        WAVE_SINE   = 2'b00,
        WAVE_SAW    = 2'b01,
        WAVE_SQUARE = 2'b10,
        WAVE_TRI    = 2'b11
    } wave_sel_e;

    // Offset sine point: mid-scale plus half-scale swing, rounded, clamped to full scale.
    function automatic int sine_point(int k, int depth, int samp_w);
        real pi_c;
        real v;
        real half;
        real top;
        pi_c = 3.141592653589793;
        half = real'(1 << (samp_w - 1));
        top  = real'((1 << samp_w) - 1);
        v = half + half * $sin(2.0 * pi_c * real'(k) / real'(depth));
        if (v > top) v = top;
        if (v < 0.0) v = 0.0;
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/dds_phase.sv
module dds_phase #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] fcw_q,
    output logic [PHASE_W-1:0] phase_q
);

    typedef struct packed {
        logic [PHASE_W-1:0] fcw;
        logic [PHASE_W-1:0] phase;
    } phase_state_t;

    phase_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + st_q.fcw;
        if (load) begin
            st_d.fcw = tune_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fcw_q   = st_q.fcw;
    assign phase_q = st_q.phase;

endmodule

// File: rtl/dds_wave.sv
module dds_wave
    import dds_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 9,
    parameter int SAMP_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase,
    input  logic [1:0]         wave_sel,
    output logic [SAMP_W-1:0]  sample_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [SAMP_W-1:0] sine_tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tab
        assign sine_tab[i] = SAMP_W'(sine_point(i, DEPTH, SAMP_W));
    end

    typedef struct packed {
        logic [SAMP_W-1:0] sample;
    } wave_state_t;

    wave_state_t       st_d, st_q;
    logic [ADDR_W-1:0] tab_addr;
    logic [SAMP_W-1:0] top_bits;
    logic [SAMP_W-1:0] saw_v, sq_v, tri_v;

    assign tab_addr = phase[PHASE_W-1 -: ADDR_W];
    assign top_bits = phase[PHASE_W-1 -: SAMP_W];
    assign saw_v    = top_bits;
    assign sq_v     = {SAMP_W{top_bits[SAMP_W-1]}};
    assign tri_v    = {top_bits[SAMP_W-2:0] ^ {(SAMP_W-1){top_bits[SAMP_W-1]}}, 1'b0};

    always_comb begin
        st_d = st_q;
        case (wave_sel_e'(wave_sel))
            WAVE_SINE:   st_d.sample = sine_tab[tab_addr];
            WAVE_SAW:    st_d.sample = saw_v;
            WAVE_SQUARE: st_d.sample = sq_v;
            default:     st_d.sample = tri_v;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_q = st_q.sample;

endmodule

// File: rtl/dds_amp.sv
module dds_amp #(
    parameter int SAMP_W = 8,
    parameter int FACT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SAMP_W-1:0] sample,
    input  logic              amp_up,
    input  logic [FACT_W-1:0] amp_factor,
    output logic [SAMP_W-1:0] out_q
);

    localparam int PROD_W = SAMP_W + FACT_W;

    typedef struct packed {
        logic [SAMP_W-1:0] out;
    } amp_state_t;

    amp_state_t        st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [FACT_W-1:0] divisor;
    logic [SAMP_W-1:0] quot;

    always_comb begin
        st_d    = st_q;
        prod    = PROD_W'(sample) * PROD_W'(amp_factor);
        divisor = (amp_factor == '0) ? FACT_W'(1) : amp_factor;
        quot    = sample / SAMP_W'(divisor);
        if (amp_up) begin
            if (prod[PROD_W-1:SAMP_W] != '0) begin
                st_d.out = '1;
            end else begin
                st_d.out = prod[SAMP_W-1:0];
            end
        end else begin
            st_d.out = quot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_q = st_q.out;

endmodule

// File: rtl/dds_siggen.sv
module dds_siggen #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 9,
    parameter int SAMP_W  = 8,
    parameter int FACT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PHASE_W-1:0] tune_word,
    input  logic [1:0]         wave_sel,
    input  logic               amp_up,
    input  logic [FACT_W-1:0]  amp_factor,
    output logic [SAMP_W-1:0]  sample_out
);

    logic [PHASE_W-1:0] fcw_q;
    logic [PHASE_W-1:0] phase_q;
    logic [SAMP_W-1:0]  wave_q;

    dds_phase #(.PHASE_W(PHASE_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tune_word (tune_word),
        .fcw_q     (fcw_q),
        .phase_q   (phase_q)
    );

    dds_wave #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase    (phase_q),
        .wave_sel (wave_sel),
        .sample_q (wave_q)
    );

    dds_amp #(.SAMP_W(SAMP_W), .FACT_W(FACT_W)) u_amp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample     (wave_q),
        .amp_up     (amp_up),
        .amp_factor (amp_factor),
        .out_q      (sample_out)
    );

endmodule

// File: rtl/dds_siggen_chk.sv
module dds_siggen_chk #(
    parameter int PHASE_W = 32,
    parameter int SAMP_W  = 8,
    parameter int FACT_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load,
    input logic [PHASE_W-1:0] tune_word,
    input logic [PHASE_W-1:0] fcw_q,
    input logic [PHASE_W-1:0] phase_q,
    input logic [1:0]         wave_sel,
    input logic               amp_up,
    input logic [FACT_W-1:0]  amp_factor,
    input logic [SAMP_W-1:0]  wave_q,
    input logic [SAMP_W-1:0]  sample_out
);

    // R1: a strobed word is captured
    a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> fcw_q == $past(tune_word));

    // R1: without the strobe the word is kept
    a_r1_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(fcw_q));

    // R2: the accumulator advances by the word held before the edge
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> phase_q == $past(phase_q) + $past(fcw_q));

    // R5: the square selection yields only the two rail values
    a_r5_square_rails: assert property (@(posedge clk) disable iff (!rst_n)
        wave_sel == 2'b10 |=> (wave_q == '0 || wave_q == '1));

    // R9: a nonzero multiply never lowers the sample
    a_r9_mul_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_up && amp_factor != '0) |=> sample_out >= $past(wave_q));

    // R10: division never raises the sample
    a_r10_div_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        !amp_up |=> sample_out <= $past(wave_q));

endmodule

bind dds_siggen dds_siggen_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W), .FACT_W(FACT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .tune_word  (tune_word),
    .fcw_q      (fcw_q),
    .phase_q    (phase_q),
    .wave_sel   (wave_sel),
    .amp_up     (amp_up),
    .amp_factor (amp_factor),
    .wave_q     (wave_q),
    .sample_out (sample_out)
);

// File: tb/dds_siggen_test.sv
module dds_siggen_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load;
    logic [31:0] tune_word;
    logic [1:0]  wave_sel;
    logic        amp_up;
    logic [2:0]  amp_factor;
    logic [7:0]  sample_out;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    string cur_req  = "R11";

    // Reference state
    bit [31:0] m_fcw, m_phase;
    int        m_samp, m_out;

    always #2.5 clk = ~clk;

    dds_siggen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .tune_word  (tune_word),
        .wave_sel   (wave_sel),
        .amp_up     (amp_up),
        .amp_factor (amp_factor),
        .sample_out (sample_out)
    );

    function automatic int sine_ref(int k);
        real v;
        v = 128.0 + 128.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 512.0);
        if (v > 255.0) v = 255.0;
        if (v < 0.0) v = 0.0;
        return $rtoi(v + 0.5);
    endfunction

    function automatic int wave_ref(bit [31:0] ph, bit [1:0] sel);
        int top;
        int lo;
        top = int'(ph >> 24);
        lo  = top % 128;
        case (sel)
            2'd0: return sine_ref(int'(ph >> 23));
            2'd1: return top;
            2'd2: return (top >= 128) ? 255 : 0;
            default: return (top >= 128) ? (127 - lo) * 2 : lo * 2;
        endcase
    endfunction

    function automatic int amp_ref(int s, bit up, int f);
        int p;
        if (up) begin
            p = s * f;
            return (p > 255) ? 255 : p;
        end
        return s / ((f == 0) ? 1 : f);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_fcw = 0; m_phase = 0; m_samp = 0; m_out = 0;
        end else begin
            m_out   = amp_ref(m_samp, amp_up, int'(amp_factor));
            m_samp  = wave_ref(m_phase, wave_sel);
            m_phase = m_phase + m_fcw;
            if (load) m_fcw = tune_word;
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking && rst_n) check(cur_req, int'(sample_out), m_out);
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_word(bit [31:0] w);
        tune_word = w; load = 1'b1;
        run(1);
        load = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; load = 1'b0; tune_word = '0;
        wave_sel = 2'b00; amp_up = 1'b1; amp_factor = 3'd1;
        run(3);
        // R11: output held at zero under reset
        check("R11", int'(sample_out), 0);
        rst_n = 1'b1;
        checking = 1'b1;

        // R3: one table entry per clock across the full period
        cur_req = "R3";
        load_word(32'h0080_0000);
        run(600);

        // R1: a new word on the bus without the strobe must be ignored
        cur_req = "R1";
        wave_sel = 2'b01;
        tune_word = 32'h1234_5678;
        run(60);

        // R4: sawtooth
        cur_req = "R4";
        load_word(32'h0123_4567);
        run(300);

        // R5: square
        cur_req = "R5";
        wave_sel = 2'b10;
        run(300);

        // R6: triangle
        cur_req = "R6";
        wave_sel = 2'b11;
        run(300);

        // R9: multiply, including saturation and a zero factor
        cur_req = "R9";
        wave_sel = 2'b00;
        amp_factor = 3'd3; run(200);
        amp_factor = 3'd7; run(200);
        amp_factor = 3'd0; run(100);

        // R10: divide, including a zero factor
        cur_req = "R10";
        amp_up = 1'b0;
        amp_factor = 3'd5; run(200);
        amp_factor = 3'd0; run(100);

        // R7/R8: selector and amplitude controls change every cycle
        cur_req = "R7/R8";
        for (int i = 0; i < 256; i++) begin
            wave_sel   = 2'(i % 4);
            amp_factor = 3'((i / 3) % 8);
            amp_up     = ((i / 16) % 2) == 0;
            run(1);
        end

        // R2: a word that wraps the accumulator
        cur_req = "R2";
        wave_sel = 2'b01; amp_up = 1'b1; amp_factor = 3'd1;
        load_word(32'hF000_0001);
        run(200);

        checking = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule